// File: doc/BRIEF.md
# Fractional Ratio Cache Clock Generator

This block derives the clock for a secondary cache RAM interface from the fast core clock. A 3-bit ratio code selects the divider. Five codes give a running clock at core/1, core/1.5, core/2, core/2.5 and core/3. Code 000 holds the interface clock off. The two remaining codes are reserved: they never produce a clock and they raise a configuration error flag. A separate bus divide input states how many core cycles one system bus cycle takes. The block flags any ratio whose cache clock would run slower than that bus.

The divided clock is not toggled on the falling core edge. Each core cycle the block registers two level bits, one for each half of the next core period. Bit 0 covers the half in which the core clock is high and bit 1 covers the half in which it is low. A clock cell next to the RAM pads selects between the two bits using the core clock itself. This gives half-integer ratios with every flop on the rising edge. The period is counted in core half-periods: 2, 3, 4, 5 or 6 halves. The high time is the larger half of that count.

A change of code while the clock runs is never abrupt. Any high pulse already in progress completes. The output then stays low for at least one whole period of the old ratio before the new ratio starts from the beginning of a pulse. If the new code is 000 or reserved, the output stays low after that pulse. A running flag marks the cycles in which a legal clock is being produced.

Top module: `ccg_top`

## Requirements
- R1: While reset is asserted, and on the first sample after it, clk_lvl is 00 and clk_on, cfg_err and rate_err are all 0.
- R2: With ratio_code 000 applied from idle, clk_lvl stays 00, clk_on stays 0 and cfg_err stays 0.
- R3: From idle, a legal code starts the clock. Codes 001, 010, 100, 101 and 110 give a period of N = 2, 3, 4, 5 and 6 core half-periods. Number the halves h from bit 0 of the first sample after the edge that took the code, with bit 0 before bit 1 in each sample. Half h is high exactly when (h mod N) < N - floor(N/2).
- R4: Codes 011 and 111 (low two bits 11) produce no clock: clk_lvl 00, clk_on 0. cfg_err is 1 in the sample after the edge that took such a code, and 0 after a non-reserved code.
- R5: clk_on rises in the same sample as the first high bit of a newly started clock, in bit 0. clk_on is 0 from the sample at which a code change takes effect until the new clock starts.
- R6: In the sample after each edge, rate_err is 1 exactly when the code taken at that edge is legal and N > 2 * bus_div.
- R7: When the code changes from a running legal ratio (N halves) to another legal ratio, a pulse already high completes unshortened. A low gap follows. It starts at or after the sample of the change. It lasts at least N and at most 2*ceil(N/2)+2 halves. The new pattern then starts in a bit 0 exactly as in R3.
- R8: When the code changes from a running ratio to 000 or a reserved code, a pulse already high completes unshortened. The output then stays 00 and clk_on ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ratio_code | input | 3 | Cache clock ratio selection code |
| bus_div | input | BUS_W | Core cycles per system bus cycle |
| clk_lvl | output | 2 | Cache clock level for the high half (bit 0) and low half (bit 1) of the next core period |
| clk_on | output | 1 | A legal cache clock is running |
| cfg_err | output | 1 | Last code taken was reserved |
| rate_err | output | 1 | Last legal code taken gives a cache clock slower than the bus |

## Verification
Every output is registered and reflects the inputs taken at the rising edge just before it. So clk_lvl, clk_on, cfg_err and rate_err are all due one core cycle after a code is applied. The bench drives on the falling edge and reads on the following falling edge. From each start or change it records a stream of half-period bits for a fixed window. It then places the pulse pattern, the low gap and the restart against the arithmetic form of R3 and R7. It does not predict the exact cycle of the gap. Only its bounds are fixed, derived from the old ratio.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } ccg_state_e;

  // Output period in core half-periods; 0 for stop and reserved codes.
  function automatic logic [2:0] half_len(input logic [2:0] code);
    case (code)
      3'b001:  half_len = 3'd2;
      3'b010:  half_len = 3'd3;
      3'b100:  half_len = 3'd4;
      3'b101:  half_len = 3'd5;
      3'b110:  half_len = 3'd6;
      default: half_len = 3'd0;
    endcase
  endfunction

  function automatic logic is_reserved(input logic [2:0] code);
    is_reserved = (code[1:0] == 2'b11);
  endfunction

  function automatic logic is_live(input logic [2:0] code);
    is_live = (code != 3'b000) && !is_reserved(code);
  endfunction

endpackage

// File: rtl/ccg_ratio_dec.sv
module ccg_ratio_dec
  import ccg_pkg::*;
#(
  parameter int HW = 3
) (
  input  logic [2:0]    code,
  output logic [HW-1:0] n2,
  output logic [HW-1:0] hi,
  output logic [HW-1:0] drain
);
  localparam logic [HW-1:0] ONE = 1;

  always_comb begin
    n2    = HW'(half_len(code));
    hi    = n2 - (n2 >> 1);
    drain = (n2 + ONE) >> 1;
  end
endmodule

// File: rtl/ccg_phase.sv
module ccg_phase #(
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          step,
  input  logic [HW-1:0] n2,
  input  logic [HW-1:0] hi,
  output logic [1:0]    pat
);
  localparam logic [HW:0] ONE = 1;
  localparam logic [HW:0] TWO = 2;

  logic [HW-1:0] ph, ph_eff;
  logic [HW:0]   n2_x, p1, p2, ph_nx;
  logic [HW:0]   p1_w;

  always_comb begin
    ph_eff = start ? '0 : ph;
    n2_x   = {1'b0, n2};
    p1     = {1'b0, ph_eff} + ONE;
    p2     = {1'b0, ph_eff} + TWO;
    p1_w   = (p1 >= n2_x) ? p1 - n2_x : p1;
    ph_nx  = (p2 >= n2_x) ? p2 - n2_x : p2;
    pat[0] = ({1'b0, ph_eff} < {1'b0, hi});
    pat[1] = (p1_w < {1'b0, hi});
  end

  always_ff @(posedge clk) begin
    if (rst)       ph <= '0;
    else if (step) ph <= ph_nx[HW-1:0];
  end
endmodule

// File: rtl/ccg_top.sv
module ccg_top
  import ccg_pkg::*;
#(
  parameter int BUS_W = 4   // must be at least 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       ratio_code,
  input  logic [BUS_W-1:0] bus_div,
  output logic [1:0]       clk_lvl,
  output logic             clk_on,
  output logic             cfg_err,
  output logic             rate_err
);
  localparam int HW = 3;
  localparam logic [HW-1:0] ONE = 1;

  ccg_state_e    st;
  logic [2:0]    act_code, sel_code;
  logic [HW-1:0] cnt, n2, hi, drain;
  logic [1:0]    pat, masked;
  logic          live_in, start, step;
  logic [BUS_W:0] n2_in_x, bus2;

  assign live_in  = is_live(ratio_code);
  assign start    = live_in && ((st == ST_IDLE) || (st == ST_DRAIN && cnt == '0));
  assign step     = start || (st == ST_RUN) || (st == ST_DRAIN);
  assign sel_code = start ? ratio_code : act_code;
  assign n2_in_x  = {{(BUS_W+1-HW){1'b0}}, half_len(ratio_code)};
  assign bus2     = {bus_div, 1'b0};

  ccg_ratio_dec #(.HW(HW)) u_dec (
    .code (sel_code),
    .n2   (n2),
    .hi   (hi),
    .drain(drain)
  );

  ccg_phase #(.HW(HW)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .step (step),
    .n2   (n2),
    .hi   (hi),
    .pat  (pat)
  );

  // Continuation mask: a half may stay high only if the half before it was high.
  always_comb begin
    masked[0] = pat[0] & clk_lvl[1];
    masked[1] = pat[1] & masked[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      act_code <= '0;
      cnt      <= '0;
      clk_lvl  <= '0;
      clk_on   <= 1'b0;
      cfg_err  <= 1'b0;
      rate_err <= 1'b0;
    end else begin
      cfg_err  <= is_reserved(ratio_code);
      rate_err <= live_in && (n2_in_x > bus2);
      case (st)
        ST_IDLE: begin
          if (start) begin
            st       <= ST_RUN;
            act_code <= ratio_code;
            clk_lvl  <= pat;
            clk_on   <= 1'b1;
          end else begin
            clk_lvl  <= '0;
            clk_on   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (ratio_code != act_code) begin
            st      <= ST_DRAIN;
            cnt     <= drain;
            clk_lvl <= masked;
            clk_on  <= 1'b0;
          end else begin
            clk_lvl <= pat;
          end
        end
        default: begin
          if (cnt == '0) begin
            if (start) begin
              st       <= ST_RUN;
              act_code <= ratio_code;
              clk_lvl  <= pat;
              clk_on   <= 1'b1;
            end else begin
              st       <= ST_IDLE;
              clk_lvl  <= '0;
            end
          end else begin
            clk_lvl <= masked;
            if (masked == 2'b00) cnt <= cnt - ONE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ccg_check.sv
module ccg_check
  import ccg_pkg::*;
#(
  parameter int BUS_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       ratio_code,
  input logic [BUS_W-1:0] bus_div,
  input logic [1:0]       clk_lvl,
  input logic             clk_on,
  input logic             cfg_err,
  input logic             rate_err
);
  logic rst_q = 1'b0;
  logic exp_rate;

  assign exp_rate = is_live(ratio_code) &&
                    ({{(BUS_W+1-3){1'b0}}, half_len(ratio_code)} > {bus_div, 1'b0});

  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_r1: assert (clk_lvl == 2'b00 && !clk_on && !cfg_err && !rate_err)
        else $error("reset state wrong");
    end
    rst_q <= rst;
  end

  // R4: reserved flag follows the code taken one edge earlier
  p_cfg_flag_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_err == is_reserved($past(ratio_code))));

  // R5: running flag rises together with a high first half
  p_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_on) |-> clk_lvl[0]);

  // R3: a running clock implies a legal code was taken
  p_on_legal_r3: assert property (@(posedge clk) disable iff (rst)
    clk_on |-> is_live($past(ratio_code)));

  // R7: once stopped and low, no pulse reappears until the clock restarts
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (!clk_on && !$past(clk_on) && !$past(clk_lvl[1])) |-> (clk_lvl == 2'b00));

  // R6: rate flag matches the previous code and bus divide
  p_rate_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rate_err == $past(exp_rate)));
endmodule

bind ccg_top ccg_check #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ratio_code(ratio_code),
  .bus_div   (bus_div),
  .clk_lvl   (clk_lvl),
  .clk_on    (clk_on),
  .cfg_err   (cfg_err),
  .rate_err  (rate_err)
);

// File: tb/sim_ccg_top.sv
module sim_ccg_top;
  localparam int BUS_W = 4;
  localparam int WC    = 30;      // recorded cycles per run
  localparam int WH    = 2 * WC;  // recorded halves

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       ratio_code = 3'b000;
  logic [BUS_W-1:0] bus_div = 4'd1;
  logic [1:0]       clk_lvl;
  logic             clk_on, cfg_err, rate_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit hb [0:WH-1];
  bit onr[0:WC-1];

  always #2.5 clk = ~clk;

  ccg_top #(.BUS_W(BUS_W)) u0 (
    .clk(clk), .rst(rst), .ratio_code(ratio_code), .bus_div(bus_div),
    .clk_lvl(clk_lvl), .clk_on(clk_on), .cfg_err(cfg_err), .rate_err(rate_err)
  );

  function automatic int nh(input int code);
    case (code)
      1: nh = 2; 2: nh = 3; 4: nh = 4; 5: nh = 5; 6: nh = 6;
      default: nh = 0;
    endcase
  endfunction

  function automatic bit expbit(input int h, input int n);
    expbit = ((h % n) < (n - n / 2));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rec(input int i);
    @(negedge clk);
    hb[2*i]   = clk_lvl[0];
    hb[2*i+1] = clk_lvl[1];
    onr[i]    = clk_on;
  endtask

  task automatic go_idle();
    ratio_code = 3'b000;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(clk_lvl == 2'b00 && !clk_on && !cfg_err && !rate_err, "R1 during reset",
        {clk_lvl, clk_on, cfg_err, rate_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(clk_lvl == 2'b00 && !clk_on && !cfg_err && !rate_err, "R1 after reset",
        {clk_lvl, clk_on, cfg_err, rate_err}, 0);

    // Start sweep from idle over every code
    for (int c = 0; c < 8; c++) begin
      int n, bad, first;
      go_idle();
      ratio_code = 3'(c);
      for (int i = 0; i < WC; i++) rec(i);
      n = nh(c);
      bad = 0; first = -1;
      for (int h = 0; h < WH; h++) begin
        bit e;
        e = (n != 0) ? expbit(h, n) : 1'b0;
        if (hb[h] != e) begin bad++; if (first < 0) first = h; end
      end
      if (n != 0) begin
        chk(bad == 0, "R3 pattern", first, -1);
        chk(onr[0] && onr[WC-1], "R5 on with first pulse", onr[0], 1);
      end else if (c == 0) begin
        chk(bad == 0 && !onr[WC-1], "R2 stop code silent", bad, 0);
        chk(!cfg_err, "R2 no cfg error", cfg_err, 0);
      end else begin
        chk(bad == 0 && !onr[WC-1], "R4 reserved silent", bad, 0);
        chk(cfg_err, "R4 cfg error", cfg_err, 1);
      end
    end

    // Rate flag sweep
    go_idle();
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 5; b++) begin
        bit e;
        ratio_code = 3'(c);
        bus_div = 4'(b);
        @(negedge clk);
        e = (nh(c) != 0) && (nh(c) > 2 * b);
        chk(rate_err == e, "R6 rate flag", rate_err, e);
        chk(cfg_err == (c == 3 || c == 7), "R4 cfg flag", cfg_err, (c == 3 || c == 7));
      end
    end
    bus_div = 4'd1;

    // Change sweep
    for (int a = 1; a < 7; a++) begin
      if (nh(a) == 0) continue;
      for (int b = 0; b < 8; b++) begin
        if (b == a || b == 7) continue;
        for (int k = 0; k < nh(a); k++) begin
          int na, nb, cc, gs, ge, gap, d, bad, first;
          na = nh(a); nb = nh(b); d = (na + 1) / 2;
          go_idle();
          ratio_code = 3'(a);
          for (int i = 0; i <= k; i++) rec(i);
          ratio_code = 3'(b);
          for (int i = k + 1; i < WC; i++) rec(i);
          cc = k + 1;
          gs = WH;
          for (int h = 2 * cc; h < WH; h++) if (!hb[h]) begin gs = h; break; end
          bad = 0; first = -1;
          for (int h = 0; h < gs; h++)
            if (hb[h] != expbit(h, na)) begin bad++; if (first < 0) first = h; end
          chk(bad == 0 && gs < WH, "R7 old pulse completes", first, -1);
          ge = WH;
          for (int h = gs + 1; h < WH; h++) if (hb[h]) begin ge = h; break; end
          gap = ge - gs;
          chk(!onr[cc], "R5 on drops at change", onr[cc], 0);
          if (nb != 0) begin
            chk(gap >= na && gap <= 2 * d + 2 && (ge % 2) == 0, "R7 gap bounds", gap, na);
            bad = 0; first = -1;
            for (int h = ge; h < WH; h++)
              if (hb[h] != expbit(h - ge, nb)) begin bad++; if (first < 0) first = h; end
            chk(bad == 0, "R7 new pattern", first, -1);
            chk(onr[ge/2] && !onr[ge/2-1], "R5 on at restart", onr[ge/2], 1);
          end else begin
            chk(ge == WH && !onr[WC-1], "R8 stays stopped", ge, WH);
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule